// File: doc/BRIEF.md
# Data Store Path with Byte-Lane Merge

This block carries one data store to its destination once address translation and the permission check have already succeeded. Each store comes with a virtual address, a physical address, the store data, a size code and a byte-order input. The block also receives the outcome of the cache lookup: a hit flag, the word index within the line and the current contents of that cached word. The page attributes of the store (bufferable or not) and a global write-buffer enable are inputs as well.

On a hit, the block places the store data into the correct byte lane of the cached word and returns the merged word through a cache-write port. Along with that word it flags which half of the line became dirty. On a miss, a bufferable store goes to a write-buffer push port when the buffer is enabled, or else straight to a memory-write port. A store to a non-bufferable page first asks for the whole write buffer to be emptied through a request/done handshake. Only after the buffer reports empty does the block issue the direct memory write. While it waits it reports busy and takes no new store.

Top module: `store_lane_path`

## Requirements
- R1: A store accepted (st_valid high while busy is low) with hit high produces, one cycle later, a one-cycle cw_valid pulse. For a word store (size code 2'b10, and also the spare code 2'b11), cw_data equals st_data and cw_be is 4'b1111.
- R2: For a halfword hit (size code 2'b01), the byte offset is (big_endian ? 2 : 0) XOR (st_va[1] ? 2 : 0). cw_data takes st_data[15:0] at that offset, and the other two bytes come from hit_word. cw_be has bits offset and offset+1 set.
- R3: For a byte hit (size code 2'b00), the byte offset is (big_endian ? 3 : 0) XOR st_va[1:0]. cw_data takes st_data[7:0] at that offset, and the other three bytes come from hit_word. cw_be has only the bit at that offset set.
- R4: With every cw_valid pulse, exactly one of cw_dirty_lo and cw_dirty_hi is high. cw_dirty_lo is high when hit_idx is below LINE_WORDS/2, and cw_dirty_hi is high otherwise.
- R5: A miss with bufferable and wb_enable both high produces, one cycle after acceptance, one wbp_valid pulse. wbp_len is 4, 2 or 1 for word, halfword or byte. wbp_addr is st_pa, st_pa|(st_va&2) or st_pa|(st_va&3) respectively. wbp_data and wbp_be use the lane placement of R2/R3, and the number of set bits in wbp_be equals wbp_len.
- R6: A miss with bufferable high and wb_enable low produces, one cycle after acceptance, one mem_valid pulse. Its address, lane data and mask are formed as in R5.
- R7: A miss with bufferable low raises busy and drain_req from the cycle after acceptance. Both stay high, and no output fires, until drain_done is sampled high. The cycle after that sample, mem_valid pulses with the address, data and mask of R5, and busy falls.
- R8: Each accepted store fires exactly one of cw_valid, wbp_valid and mem_valid, and st_done pulses in the same cycle. No two of these valids are ever high together.
- R9: st_valid is ignored while busy is high: no output pulse results from it.
- R10: While reset is asserted and right after it is released, all valid outputs, st_done, busy and drain_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request; taken when busy is low |
| st_va | input | ADDR_W | Virtual address of the store |
| st_pa | input | ADDR_W | Translated physical address |
| st_data | input | 32 | Store data, right-aligned |
| st_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| big_endian | input | 1 | Byte order select |
| hit | input | 1 | Cache lookup hit |
| hit_idx | input | IDX_W | Word index of the hit within its line |
| hit_word | input | 32 | Current contents of the hit word |
| bufferable | input | 1 | Page allows buffered writes |
| wb_enable | input | 1 | Write buffer enabled |
| drain_done | input | 1 | Write buffer reports empty |
| busy | output | 1 | Waiting on a drain; no store accepted |
| drain_req | output | 1 | Request to empty the write buffer |
| st_done | output | 1 | Store completion pulse |
| cw_valid | output | 1 | Cache word write pulse |
| cw_idx | output | IDX_W | Word index to write |
| cw_data | output | 32 | Merged word |
| cw_be | output | 4 | Bytes changed by the store |
| cw_dirty_lo | output | 1 | Mark first half of line dirty |
| cw_dirty_hi | output | 1 | Mark second half of line dirty |
| wbp_valid | output | 1 | Write-buffer push pulse |
| wbp_addr | output | ADDR_W | Push address |
| wbp_data | output | 32 | Lane-placed data |
| wbp_be | output | 4 | Byte mask |
| wbp_len | output | 3 | Length in bytes |
| mem_valid | output | 1 | Direct memory write pulse |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | 32 | Lane-placed data |
| mem_be | output | 4 | Byte mask |

## Verification
The hardest situation to reach is a second store arriving while a drain is still outstanding, because the window exists only between the drain request and the done handshake. The stimulus holds drain_done low for several cycles after a non-bufferable miss and, inside that window, raises st_valid with a hit store that would otherwise produce a cache write. The scoreboard then shows that the only output is the single delayed memory write. Lane placement is covered by stepping the low address bits through every value under both byte orders, and the dirty-half decision is tested at the indices on either side of the line midpoint.

// File: rtl/store_lane_pkg.sv
package store_lane_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_BITS  = 8 * WORD_BYTES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } st_size_e;

    typedef enum logic {
        RT_IDLE  = 1'b0,
        RT_DRAIN = 1'b1
    } rt_state_e;

    typedef struct packed {
        logic [WORD_BITS-1:0]  data;
        logic [WORD_BYTES-1:0] be;
        logic [1:0]            low;
        logic [2:0]            len;
    } lane_t;

    // Place store data into its byte lane; low is the address offset to OR in.
    function automatic lane_t place_lane(input logic [1:0] size,
                                         input logic big,
                                         input logic [1:0] va_lo,
                                         input logic [WORD_BITS-1:0] d);
        lane_t      r;
        logic [1:0] off;
        case (st_size_e'(size))
            SZ_BYTE: begin
                off    = (big ? 2'd3 : 2'd0) ^ va_lo;
                r.be   = 4'b0001 << off;
                r.data = {24'h0, d[7:0]} << {off, 3'b000};
                r.low  = va_lo;
                r.len  = 3'd1;
            end
            SZ_HALF: begin
                off    = (big ? 2'd2 : 2'd0) ^ {va_lo[1], 1'b0};
                r.be   = 4'b0011 << off;
                r.data = {16'h0, d[15:0]} << {off, 3'b000};
                r.low  = {va_lo[1], 1'b0};
                r.len  = 3'd2;
            end
            default: begin
                r.be   = 4'b1111;
                r.data = d;
                r.low  = 2'b00;
                r.len  = 3'd4;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/store_lane_align.sv
module store_lane_align
    import store_lane_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]    va,
    input  logic [ADDR_W-1:0]    pa,
    input  logic [1:0]           size,
    input  logic                 big,
    input  logic [WORD_BITS-1:0] data,
    output lane_t                lane,
    output logic [ADDR_W-1:0]    addr
);
    always_comb begin
        lane = place_lane(size, big, va[1:0], data);
        addr = pa | {{(ADDR_W-2){1'b0}}, lane.low};
    end
endmodule

// File: rtl/store_lane_merge.sv
module store_lane_merge
    import store_lane_pkg::*;
#(
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int HALF      = LINE_WORDS / 2
) (
    input  lane_t                lane,
    input  logic [WORD_BITS-1:0] old_word,
    input  logic [IDX_W-1:0]     idx,
    output logic [WORD_BITS-1:0] merged,
    output logic                 dirty_lo,
    output logic                 dirty_hi
);
    logic [WORD_BITS-1:0] bit_mask;

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_mask
        assign bit_mask[8*b +: 8] = {8{lane.be[b]}};
    end

    always_comb begin
        merged   = (old_word & ~bit_mask) | (lane.data & bit_mask);
        dirty_lo = (int'(idx) < HALF);
        dirty_hi = ~dirty_lo;
    end
endmodule

// File: rtl/store_lane_route.sv
module store_lane_route
    import store_lane_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  st_valid,
    input  logic                  hit,
    input  logic                  bufferable,
    input  logic                  wb_enable,
    input  logic                  drain_done,
    input  lane_t                 lane,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_BITS-1:0]  merged,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  dirty_lo,
    input  logic                  dirty_hi,
    output logic                  busy,
    output logic                  drain_req,
    output logic                  st_done,
    output logic                  cw_valid,
    output logic [IDX_W-1:0]      cw_idx,
    output logic [WORD_BITS-1:0]  cw_data,
    output logic [WORD_BYTES-1:0] cw_be,
    output logic                  cw_dirty_lo,
    output logic                  cw_dirty_hi,
    output logic                  wbp_valid,
    output logic [ADDR_W-1:0]     wbp_addr,
    output logic [WORD_BITS-1:0]  wbp_data,
    output logic [WORD_BYTES-1:0] wbp_be,
    output logic [2:0]            wbp_len,
    output logic                  mem_valid,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [WORD_BITS-1:0]  mem_data,
    output logic [WORD_BYTES-1:0] mem_be
);
    rt_state_e             state;
    logic [ADDR_W-1:0]     held_addr;
    logic [WORD_BITS-1:0]  held_data;
    logic [WORD_BYTES-1:0] held_be;
    logic                  accept;

    assign accept    = st_valid && (state == RT_IDLE);
    assign busy      = (state == RT_DRAIN);
    assign drain_req = (state == RT_DRAIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= RT_IDLE;
            st_done     <= 1'b0;
            cw_valid    <= 1'b0;
            wbp_valid   <= 1'b0;
            mem_valid   <= 1'b0;
            cw_idx      <= '0;
            cw_data     <= '0;
            cw_be       <= '0;
            cw_dirty_lo <= 1'b0;
            cw_dirty_hi <= 1'b0;
            wbp_addr    <= '0;
            wbp_data    <= '0;
            wbp_be      <= '0;
            wbp_len     <= '0;
            mem_addr    <= '0;
            mem_data    <= '0;
            mem_be      <= '0;
            held_addr   <= '0;
            held_data   <= '0;
            held_be     <= '0;
        end else begin
            st_done   <= 1'b0;
            cw_valid  <= 1'b0;
            wbp_valid <= 1'b0;
            mem_valid <= 1'b0;
            if (accept) begin
                if (hit) begin
                    cw_valid    <= 1'b1;
                    cw_idx      <= idx;
                    cw_data     <= merged;
                    cw_be       <= lane.be;
                    cw_dirty_lo <= dirty_lo;
                    cw_dirty_hi <= dirty_hi;
                    st_done     <= 1'b1;
                end else if (bufferable && wb_enable) begin
                    wbp_valid <= 1'b1;
                    wbp_addr  <= addr;
                    wbp_data  <= lane.data;
                    wbp_be    <= lane.be;
                    wbp_len   <= lane.len;
                    st_done   <= 1'b1;
                end else if (bufferable) begin
                    mem_valid <= 1'b1;
                    mem_addr  <= addr;
                    mem_data  <= lane.data;
                    mem_be    <= lane.be;
                    st_done   <= 1'b1;
                end else begin
                    state     <= RT_DRAIN;
                    held_addr <= addr;
                    held_data <= lane.data;
                    held_be   <= lane.be;
                end
            end else if (state == RT_DRAIN && drain_done) begin
                state     <= RT_IDLE;
                mem_valid <= 1'b1;
                mem_addr  <= held_addr;
                mem_data  <= held_data;
                mem_be    <= held_be;
                st_done   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/store_lane_path.sv
module store_lane_path
    import store_lane_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  st_valid,
    input  logic [ADDR_W-1:0]     st_va,
    input  logic [ADDR_W-1:0]     st_pa,
    input  logic [WORD_BITS-1:0]  st_data,
    input  logic [1:0]            st_size,
    input  logic                  big_endian,
    input  logic                  hit,
    input  logic [IDX_W-1:0]      hit_idx,
    input  logic [WORD_BITS-1:0]  hit_word,
    input  logic                  bufferable,
    input  logic                  wb_enable,
    input  logic                  drain_done,
    output logic                  busy,
    output logic                  drain_req,
    output logic                  st_done,
    output logic                  cw_valid,
    output logic [IDX_W-1:0]      cw_idx,
    output logic [WORD_BITS-1:0]  cw_data,
    output logic [WORD_BYTES-1:0] cw_be,
    output logic                  cw_dirty_lo,
    output logic                  cw_dirty_hi,
    output logic                  wbp_valid,
    output logic [ADDR_W-1:0]     wbp_addr,
    output logic [WORD_BITS-1:0]  wbp_data,
    output logic [WORD_BYTES-1:0] wbp_be,
    output logic [2:0]            wbp_len,
    output logic                  mem_valid,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [WORD_BITS-1:0]  mem_data,
    output logic [WORD_BYTES-1:0] mem_be
);
    lane_t                lane;
    logic [ADDR_W-1:0]    addr;
    logic [WORD_BITS-1:0] merged;
    logic                 dirty_lo, dirty_hi;

    store_lane_align #(.ADDR_W(ADDR_W)) u_align (
        .va(st_va), .pa(st_pa), .size(st_size), .big(big_endian),
        .data(st_data), .lane(lane), .addr(addr)
    );

    store_lane_merge #(.LINE_WORDS(LINE_WORDS)) u_merge (
        .lane(lane), .old_word(hit_word), .idx(hit_idx),
        .merged(merged), .dirty_lo(dirty_lo), .dirty_hi(dirty_hi)
    );

    store_lane_route #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_route (
        .clk(clk), .rst(rst), .st_valid(st_valid), .hit(hit),
        .bufferable(bufferable), .wb_enable(wb_enable), .drain_done(drain_done),
        .lane(lane), .addr(addr), .merged(merged), .idx(hit_idx),
        .dirty_lo(dirty_lo), .dirty_hi(dirty_hi),
        .busy(busy), .drain_req(drain_req), .st_done(st_done),
        .cw_valid(cw_valid), .cw_idx(cw_idx), .cw_data(cw_data), .cw_be(cw_be),
        .cw_dirty_lo(cw_dirty_lo), .cw_dirty_hi(cw_dirty_hi),
        .wbp_valid(wbp_valid), .wbp_addr(wbp_addr), .wbp_data(wbp_data),
        .wbp_be(wbp_be), .wbp_len(wbp_len),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_be(mem_be)
    );
endmodule

// File: rtl/store_lane_checker.sv
module store_lane_checker (
    input logic       clk,
    input logic       rst,
    input logic       st_valid,
    input logic       hit,
    input logic       bufferable,
    input logic       wb_enable,
    input logic       drain_done,
    input logic       busy,
    input logic       drain_req,
    input logic       st_done,
    input logic       cw_valid,
    input logic       cw_dirty_lo,
    input logic       cw_dirty_hi,
    input logic       wbp_valid,
    input logic [3:0] wbp_be,
    input logic [2:0] wbp_len,
    input logic       mem_valid
);
    assert_one_port_R8: assert property (@(posedge clk) disable iff (rst)
        $countones({cw_valid, wbp_valid, mem_valid}) == (st_done ? 1 : 0));

    assert_hit_write_R1: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !busy && hit) |=> cw_valid);

    assert_dirty_half_R4: assert property (@(posedge clk) disable iff (rst)
        cw_valid |-> (cw_dirty_lo ^ cw_dirty_hi));

    assert_push_len_R5: assert property (@(posedge clk) disable iff (rst)
        wbp_valid |-> ($countones(wbp_be) == int'(wbp_len)));

    assert_direct_R6: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !busy && !hit && bufferable && !wb_enable) |=> mem_valid);

    assert_drain_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !drain_done) |=> (busy && drain_req && !mem_valid));

    assert_drain_release_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && drain_done) |=> (mem_valid && !busy));

    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !drain_done) |=> !(cw_valid || wbp_valid));
endmodule

bind store_lane_path store_lane_checker u_store_lane_checker (.*);

// File: tb/store_lane_path_bench.sv
module store_lane_path_bench;
    localparam int LW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 0, big_endian = 0, hit = 0, bufferable = 0;
    logic        wb_enable = 0, drain_done = 0;
    logic [31:0] st_va = 0, st_pa = 0, st_data = 0, hit_word = 0;
    logic [1:0]  st_size = 0;
    logic [2:0]  hit_idx = 0;
    logic        busy, drain_req, st_done, cw_valid, cw_dirty_lo, cw_dirty_hi;
    logic        wbp_valid, mem_valid;
    logic [2:0]  cw_idx, wbp_len;
    logic [31:0] cw_data, wbp_addr, wbp_data, mem_addr, mem_data;
    logic [3:0]  cw_be, wbp_be, mem_be;

    always #2 clk = ~clk;

    store_lane_path #(.ADDR_W(32), .LINE_WORDS(LW)) u_store_lane_path (.*);

    typedef struct {
        int          port;
        logic [31:0] addr, data;
        logic [3:0]  be;
        int          len, idx;
        logic        dlo;
        string       req;
    } exp_t;

    exp_t q[$];
    int   checks = 0, errors = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard whenever an output port fires.
    always @(negedge clk) begin
        if (!rst) begin
            int nv;
            nv = int'(cw_valid) + int'(wbp_valid) + int'(mem_valid);
            if (nv > 1) chk(0, "R8 multiple ports", nv, 1);
            if (st_done != (nv != 0)) chk(0, "R8 st_done", st_done, nv != 0);
            if (nv != 0) begin
                if (q.size() == 0) begin
                    chk(0, "R9 unexpected output", {cw_valid, wbp_valid, mem_valid}, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.port == 0) begin
                        chk(cw_valid, {e.req, " port"}, {cw_valid, wbp_valid, mem_valid}, 4);
                        chk(cw_data == e.data, {e.req, " cw_data"}, cw_data, e.data);
                        chk(cw_be == e.be, {e.req, " cw_be"}, cw_be, e.be);
                        chk(int'(cw_idx) == e.idx, {e.req, " cw_idx"}, cw_idx, e.idx);
                        chk(cw_dirty_lo == e.dlo && cw_dirty_hi == !e.dlo, "R4 dirty half",
                            {cw_dirty_lo, cw_dirty_hi}, {e.dlo, !e.dlo});
                    end else if (e.port == 1) begin
                        chk(wbp_valid, {e.req, " port"}, {cw_valid, wbp_valid, mem_valid}, 2);
                        chk(wbp_addr == e.addr, {e.req, " wbp_addr"}, wbp_addr, e.addr);
                        chk(wbp_data == e.data, {e.req, " wbp_data"}, wbp_data, e.data);
                        chk(wbp_be == e.be, {e.req, " wbp_be"}, wbp_be, e.be);
                        chk(int'(wbp_len) == e.len, {e.req, " wbp_len"}, wbp_len, e.len);
                    end else begin
                        chk(mem_valid, {e.req, " port"}, {cw_valid, wbp_valid, mem_valid}, 1);
                        chk(mem_addr == e.addr, {e.req, " mem_addr"}, mem_addr, e.addr);
                        chk(mem_data == e.data, {e.req, " mem_data"}, mem_data, e.data);
                        chk(mem_be == e.be, {e.req, " mem_be"}, mem_be, e.be);
                    end
                end
            end
        end
    end

    // Driver: computes the expected item from the requirements and drives the store.
    task automatic do_store(input logic [31:0] va, input logic [31:0] pa, input logic [31:0] d,
                            input logic [1:0] sz, input logic big, input logic h, input int idx,
                            input logic [31:0] old, input logic bf, input logic we,
                            input string req);
        exp_t e;
        int off, len;
        logic [31:0] a, pd, msk;
        logic [3:0] be;
        if (sz == 2'b00) begin
            off = (big ? 3 : 0) ^ int'(va[1:0]); a = pa | (va & 32'h3);
            be = 4'b0001 << off; pd = {24'h0, d[7:0]} << (8 * off); len = 1;
        end else if (sz == 2'b01) begin
            off = (big ? 2 : 0) ^ (va[1] ? 2 : 0); a = pa | (va & 32'h2);
            be = 4'b0011 << off; pd = {16'h0, d[15:0]} << (8 * off); len = 2;
        end else begin
            off = 0; a = pa; be = 4'hF; pd = d; len = 4;
        end
        for (int b = 0; b < 4; b++) msk[8*b +: 8] = {8{be[b]}};
        e.addr = a; e.data = pd; e.be = be; e.len = len; e.idx = idx;
        e.dlo = (idx < LW / 2); e.req = req;
        if (h) begin
            e.port = 0; e.data = (old & ~msk) | pd;
        end else if (bf && we) e.port = 1;
        else e.port = 2;
        q.push_back(e);

        while (busy) @(negedge clk);
        st_va = va; st_pa = pa; st_data = d; st_size = sz; big_endian = big;
        hit = h; hit_idx = idx[2:0]; hit_word = old; bufferable = bf; wb_enable = we;
        st_valid = 1;
        @(negedge clk);
        st_valid = 0;
        if (!h && !bf) begin
            chk(busy && drain_req, "R7 drain requested", {busy, drain_req}, 2'b11);
            for (int w = 0; w < 4; w++) begin
                if (w == 1) begin
                    // store offered during the drain must be dropped (R9)
                    hit = 1; hit_idx = 3'd1; st_valid = 1;
                end else begin
                    st_valid = 0;
                end
                @(negedge clk);
                chk(drain_req && busy, "R7 drain held", {busy, drain_req}, 2'b11);
                chk(q.size() == 1, "R7 no early write", q.size(), 1);
            end
            st_valid = 0; hit = 0;
            drain_done = 1;
            @(negedge clk);
            drain_done = 0;
            chk(!busy && !drain_req, "R7 drain released", {busy, drain_req}, 0);
            @(negedge clk);
            chk(q.size() == 0, "R9 only the held write", q.size(), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!cw_valid && !wbp_valid && !mem_valid && !st_done && !busy && !drain_req,
            "R10 during reset", {cw_valid, wbp_valid, mem_valid, st_done, busy, drain_req}, 0);
        rst = 0;
        @(negedge clk);
        chk(!cw_valid && !wbp_valid && !mem_valid && !st_done && !busy && !drain_req,
            "R10 after reset", {cw_valid, wbp_valid, mem_valid, st_done, busy, drain_req}, 0);

        // Hits: word, halfword and byte lanes in both byte orders
        do_store(32'h0000_1000, 32'h8000_1000, 32'hCAFE_BABE, 2'b10, 0, 1, 2, 32'h1111_1111, 1, 1, "R1");
        do_store(32'h0000_1004, 32'h8000_1004, 32'h0BAD_F00D, 2'b11, 1, 1, 3, 32'h2222_2222, 0, 0, "R1");
        do_store(32'h0000_1002, 32'h8000_1000, 32'h0000_ABCD, 2'b01, 0, 1, 4, 32'h3344_5566, 1, 1, "R2");
        do_store(32'h0000_1000, 32'h8000_1000, 32'hFFFF_1234, 2'b01, 0, 1, 5, 32'h3344_5566, 1, 1, "R2");
        do_store(32'h0000_1000, 32'h8000_1000, 32'h0000_BEEF, 2'b01, 1, 1, 0, 32'hA1B2_C3D4, 1, 1, "R2");
        do_store(32'h0000_1002, 32'h8000_1000, 32'h0000_5A5A, 2'b01, 1, 1, 7, 32'hA1B2_C3D4, 1, 1, "R2");
        for (int v = 0; v < 4; v++) begin
            do_store(32'h0000_2000 | v, 32'h8000_2000, 32'h0000_00E0 | v, 2'b00, 0, 1, v + 2,
                     32'h0102_0304, 1, 1, "R3");
            do_store(32'h0000_2000 | v, 32'h8000_2000, 32'h0000_0070 | v, 2'b00, 1, 1, 6 - v,
                     32'h0102_0304, 0, 1, "R3");
        end

        // Miss, bufferable, write buffer on
        do_store(32'h0000_3003, 32'h4000_0040, 32'hDEAD_BEEF, 2'b10, 0, 0, 0, 0, 1, 1, "R5");
        do_store(32'h0000_3003, 32'h4000_0040, 32'h0000_7788, 2'b01, 0, 0, 0, 0, 1, 1, "R5");
        do_store(32'h0000_3003, 32'h4000_0040, 32'h0000_0099, 2'b00, 1, 0, 0, 0, 1, 1, "R5");
        do_store(32'h0000_3001, 32'h4000_0044, 32'h0000_0042, 2'b00, 0, 0, 0, 0, 1, 1, "R5");

        // Miss, bufferable, write buffer off
        do_store(32'h0000_3002, 32'h4000_0080, 32'h0000_1357, 2'b01, 1, 0, 0, 0, 1, 0, "R6");
        do_store(32'h0000_3001, 32'h4000_0080, 32'h0000_00AB, 2'b00, 0, 0, 0, 0, 1, 0, "R6");

        // Miss, non-bufferable: drain first
        do_store(32'h0000_4000, 32'h5000_0000, 32'h600D_CAFE, 2'b10, 0, 0, 0, 0, 0, 1, "R7");
        do_store(32'h0000_4002, 32'h5000_0010, 32'h0000_00C3, 2'b00, 1, 0, 0, 0, 0, 0, "R7");

        // Store right after a drain completes
        do_store(32'h0000_5001, 32'h5000_0020, 32'h0000_0011, 2'b00, 0, 1, 1, 32'hFFFF_FFFF, 1, 1, "R8");

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R8 all stores completed", q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end
endmodule